// File: doc/BRIEF.md
# Decade-Counter Keyboard Matrix Scanner

This block models the keyboard end of a matrix scan link. Seventy-two key states, arranged as nine rows of eight columns, arrive on a flat input vector. The block shows them four bits at a time on a parallel data output. One input line does two jobs. Its level picks which half of the current row is visible, and its rising edge steps an internal row counter. The counter has ten positions. The last position has no keys behind it and always reads as zero. A separate scan reset input returns the counter to the first row.

The select/clock line comes from another clock domain. It passes through a synchronizer and is edge-detected against the system clock, so it never clocks any flop directly. A host scans the block in a fixed order. It pulses scan reset once, then reads the low half of a row, raises the line to read the high half (which also moves to the next row), lowers it, and repeats. With this order the high half it reads always belongs to the row the rising edge has just selected.

Top module: `kbd_scan_top`

## Requirements
- R1: While `rst` is high, the row counter is held at row 0 and `data_out` is held at 0.
- R2: With the synchronized select level low, `data_out[i]` equals `keys[row*8 + i]` for i = 0..3, which are columns 0-3 of the current row. A 1 means the key is pressed.
- R3: With the synchronized select level high, `data_out[i]` equals `keys[row*8 + 4 + i]` for i = 0..3, which are columns 4-7 of the current row.
- R4: Each rising edge of `sel_clk` advances the row by exactly one. A falling edge does not change the row.
- R5: The counter has ten states, rows 0 to 9. A rising edge taken in row 9 returns it to row 0.
- R6: In row 9, `data_out` is 0 whatever the keys and the select level.
- R7: `scan_rst` is synchronous. When it is sampled high at a clock edge, that same edge puts the counter at row 0, and `data_out` shows row 0.
- R8: When `scan_rst` is high at the edge where a rising edge of `sel_clk` is detected, the counter goes to row 0 and does not advance.
- R9: `sel_clk` passes through a two-flop synchronizer. A change on it is not visible on `data_out` one clock edge after it is applied. It is visible at the third edge.
- R10: A change on `keys` shows on `data_out` at the first clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| scan_rst | input | 1 | Synchronous return of the row counter to row 0 |
| sel_clk | input | 1 | Asynchronous half select (level) and row advance (rising edge) |
| keys | input | 72 | Key states, index row*8 + column, 1 = pressed |
| data_out | output | 4 | Registered half-row of key states |

## Verification
There are three latencies to check. A change on `keys` appears on `data_out` one edge later. A `scan_rst` pulse shows row 0 one edge later. A `sel_clk` change passes two synchronizer flops and one output register, so it appears three edges later. The bench drives every input on the falling clock edge. It then waits the exact number of rising edges for that stimulus and samples on the following falling edge. For `sel_clk` it also samples one edge after the change, to confirm the output has not moved yet. For R8 the bench holds `scan_rst` high across the whole synchronizer delay, so the reset is present at the edge where the rising edge is detected.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int unsigned KS_ROWS      = 9;
  localparam int unsigned KS_COLS      = 8;
  localparam int unsigned KS_SYNC_DEPTH = 2;
endpackage

// File: rtl/kbd_sel_sync.sv
module kbd_sel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  // chain[0] samples the asynchronous line; each later stage samples the one before it
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= async_in;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  // last holds the previous synchronized level, for edge detection
  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/kbd_row_counter.sv
module kbd_row_counter #(
  parameter int unsigned STEPS = 10,
  localparam int unsigned CW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] row_q,
  output logic [CW-1:0] row_d
);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  // clear wins over step
  always_comb begin
    row_d = row_q;
    if (clr)
      row_d = '0;
    else if (step)
      row_d = (row_q == LAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) row_q <= '0;
    else     row_q <= row_d;
  end
endmodule

// File: rtl/kbd_half_mux.sv
module kbd_half_mux #(
  parameter int unsigned ROWS = 9,
  parameter int unsigned COLS = 8,
  localparam int unsigned HALF = COLS / 2,
  localparam int unsigned CW   = $clog2(ROWS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*COLS-1:0] keys,
  input  logic [CW-1:0]        row,
  input  logic                 upper,
  output logic [HALF-1:0]      data_q
);
  logic [HALF-1:0] data_d;

  // any row number without keys behind it (the blank step) falls through as zero
  always_comb begin
    data_d = '0;
    for (int r = 0; r < int'(ROWS); r++) begin
      if (row == CW'(r))
        data_d = upper ? keys[r*COLS + HALF +: HALF] : keys[r*COLS +: HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= data_d;
  end
endmodule

// File: rtl/kbd_scan_top.sv
module kbd_scan_top
  import kbd_scan_pkg::*;
#(
  parameter int unsigned ROWS       = KS_ROWS,
  parameter int unsigned COLS       = KS_COLS,
  parameter int unsigned SYNC_DEPTH = KS_SYNC_DEPTH,
  localparam int unsigned STEPS     = ROWS + 1,
  localparam int unsigned CW        = $clog2(STEPS),
  localparam int unsigned HALF      = COLS / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_rst,
  input  logic                 sel_clk,
  input  logic [ROWS*COLS-1:0] keys,
  output logic [HALF-1:0]      data_out
);
  logic          sel_level;
  logic          sel_rise;
  logic [CW-1:0] row_q;
  logic [CW-1:0] row_d;

  kbd_sel_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sel_clk),
    .level    (sel_level),
    .rise     (sel_rise)
  );

  kbd_row_counter #(.STEPS(STEPS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (scan_rst),
    .step  (sel_rise),
    .row_q (row_q),
    .row_d (row_d)
  );

  // the mux is fed the counter's next value, so the output register and
  // row_q are loaded at the same edge and never disagree
  kbd_half_mux #(.ROWS(ROWS), .COLS(COLS)) u_mux (
    .clk    (clk),
    .rst    (rst),
    .keys   (keys),
    .row    (row_d),
    .upper  (sel_level),
    .data_q (data_out)
  );
endmodule

// File: rtl/kbd_scan_chk.sv
module kbd_scan_chk #(
  parameter int unsigned CW    = 4,
  parameter int unsigned STEPS = 10,
  parameter int unsigned HALF  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            scan_rst,
  input logic            sel_rise,
  input logic [CW-1:0]   row_q,
  input logic [HALF-1:0] data_out
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (row_q == '0 && data_out == '0));

  // R5
  row_range_chk: assert property (@(posedge clk) disable iff (rst)
    row_q < CW'(STEPS));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_rise && !scan_rst && row_q != CW'(STEPS-1)) |=> row_q == $past(row_q) + 1'b1);

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_rise && !scan_rst && row_q == CW'(STEPS-1)) |=> row_q == '0);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_rise && !scan_rst) |=> $stable(row_q));

  // R7 R8
  scan_clear_chk: assert property (@(posedge clk) disable iff (rst)
    scan_rst |=> row_q == '0);

  // R6
  blank_row_chk: assert property (@(posedge clk) disable iff (rst)
    row_q == CW'(STEPS-1) |-> data_out == '0);
endmodule

bind kbd_scan_top kbd_scan_chk #(.CW(CW), .STEPS(STEPS), .HALF(HALF)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scan_rst (scan_rst),
  .sel_rise (sel_rise),
  .row_q    (row_q),
  .data_out (data_out)
);

// File: tb/test_kbd_scan_top.sv
module test_kbd_scan_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 9;
  localparam int COLS = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 scan_rst = 1'b0;
  logic                 sel_clk = 1'b0;
  logic [ROWS*COLS-1:0] keys = '0;
  logic [3:0]           data_out;

  int n_cmp = 0;
  int n_bad = 0;
  int m_row = 0;
  logic m_sel = 1'b0;
  bit done = 1'b0;

  kbd_scan_top i_kbd_scan_top (
    .clk      (clk),
    .rst      (rst),
    .scan_rst (scan_rst),
    .sel_clk  (sel_clk),
    .keys     (keys),
    .data_out (data_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] expect_half(logic [ROWS*COLS-1:0] k, int row, logic up);
    logic [3:0] v;
    v = '0;
    if (row < ROWS)
      for (int i = 0; i < 4; i++) v[i] = k[row*COLS + (up ? 4 : 0) + i];
    return v;
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (row %0d sel %0b)", req, got, exp, m_row, m_sel);
    end
  endtask

  task automatic check_model(string req);
    check(req, data_out, expect_half(keys, m_row, m_sel));
  endtask

  // drive at the falling edge; the result is due three rising edges later
  task automatic set_sel(logic v, string req);
    @(negedge clk);
    sel_clk = v;
    @(posedge clk);
    @(negedge clk);
    check({req, " R9 hold"}, data_out, expect_half(keys, m_row, m_sel));
    if (v && !m_sel) m_row = (m_row + 1) % (ROWS + 1);
    m_sel = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_model(req);
  endtask

  task automatic pulse_scan_rst(string req);
    @(negedge clk);
    scan_rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    scan_rst = 1'b0;
    m_row = 0;
    check_model(req);
  endtask

  task automatic new_keys(logic [ROWS*COLS-1:0] k, string req);
    @(negedge clk);
    keys = k;
    @(posedge clk);
    @(negedge clk);
    check_model(req);
  endtask

  function automatic logic [ROWS*COLS-1:0] rand_keys();
    logic [ROWS*COLS-1:0] k;
    for (int w = 0; w < (ROWS*COLS+31)/32; w++) k[w*32 +: 32] = $urandom;
    return k;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    keys = rand_keys();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", data_out, 4'h0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_model("R2 row0 low");

    // walk all ten steps with distinct keys per row
    keys = rand_keys();
    for (int s = 0; s < 11; s++) begin
      set_sel(1'b1, m_row == 9 ? "R5 wrap high" : "R3 R4 high half");
      set_sel(1'b0, m_row == 9 ? "R6 blank low" : "R2 R4 low half");
    end

    // blank row with every key pressed
    while (m_row != 8) begin
      set_sel(1'b1, "R4 step");
      set_sel(1'b0, "R4 step");
    end
    new_keys('1, "R10 all pressed");
    set_sel(1'b1, "R6 blank high all keys");
    set_sel(1'b0, "R6 blank low all keys");
    set_sel(1'b1, "R5 wrap to row0");
    check("R5 row0 high", data_out, 4'hF);

    // scan reset from mid-scan
    set_sel(1'b0, "R2 low");
    set_sel(1'b1, "R4 step");
    set_sel(1'b0, "R4 step");
    new_keys(rand_keys(), "R10 key change");
    pulse_scan_rst("R7 scan reset");

    // scan reset held across a detected rising edge
    set_sel(1'b1, "R4 step");
    set_sel(1'b0, "R4 step");
    @(negedge clk);
    sel_clk = 1'b1;
    scan_rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    scan_rst = 1'b0;
    m_row = 0;
    m_sel = 1'b1;
    check_model("R8 reset beats step");
    @(posedge clk);
    @(negedge clk);
    check_model("R8 no late step");

    // random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 4)
        0: set_sel(~m_sel, "R4 random select");
        1: new_keys(rand_keys(), "R10 random keys");
        2: pulse_scan_rst("R7 random scan reset");
        default: begin
          @(negedge clk);
          check_model(m_sel ? "R3 random idle" : "R2 random idle");
        end
      endcase
    end

    // block reset mid-scan
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset mid-scan", data_out, 4'h0);
    sel_clk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_row = 0;
    m_sel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_model("R1 row0 after reset");
    finish_run();
  end
endmodule